// File: doc/BRIEF.md
# Paged Call/Jump Branch Sequencer

This block carries out the two-byte, page-local branch instructions of an 8-bit microcontroller core. It is handed the address of the branch instruction, its opcode byte, its second byte, the current stack pointer and a flag that says whether the instruction is a call or a plain jump. It first advances the program counter past the two-byte instruction. It then forms a target that keeps the page bits of that advanced counter and replaces only the in-page offset.

For a jump, the block presents the new program counter in the cycle after it accepts the instruction. For a call, it first stores the advanced counter on the internal-RAM stack. The low byte goes first and the high byte second, each at the next pre-incremented stack slot. After that it loads the program counter and hands back the stack pointer raised by two. A busy output covers the whole sequence. While busy is high, further start requests are ignored.

Top module: `abs_branch_seq`

## Requirements
- R1: After reset, busy, pc_load, sp_load and ram_we are all low.
- R2: The advanced counter is pc_in + 2 (modulo 2^16). The loaded target is {advanced[15:11], op_byte[7:5], addr_byte}.
- R3: The page bits of the target are taken from the advanced counter, not from pc_in. When the instruction sits in the last two bytes of a page, the target therefore lies in the next page.
- R4: For a call, in the first cycle after acceptance, ram_we is high, ram_addr is sp_in + 1 and ram_wdata is the advanced counter's bits 7:0.
- R5: For a call, in the second cycle after acceptance, ram_we is high, ram_addr is sp_in + 2 and ram_wdata is the advanced counter's bits 15:8.
- R6: For a call, in the third cycle after acceptance, pc_load and sp_load are high and sp_out is sp_in + 2 modulo 256. The slot addresses wrap from 0xFF to 0x00 in the same way.
- R7: For a jump (is_call = 0), pc_load is high in the first cycle after acceptance. No cycle of that jump raises ram_we or sp_load.
- R8: busy is high from the cycle after acceptance through the pc_load cycle and low in the following cycle. A start request that arrives while busy is high is ignored, and so are input changes after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to execute a branch; taken when busy is low |
| is_call | input | 1 | 1 = call with stack push, 0 = jump only |
| pc_in | input | 16 | Address of the branch instruction |
| op_byte | input | 8 | Opcode byte; bits 7:5 give target bits 10:8 |
| addr_byte | input | 8 | Second instruction byte; target bits 7:0 |
| sp_in | input | 8 | Stack pointer before the instruction |
| busy | output | 1 | Sequence in progress |
| pc_load | output | 1 | Strobe: load pc_out into the program counter |
| pc_out | output | 16 | Branch target, valid with pc_load |
| sp_load | output | 1 | Strobe: load sp_out into the stack pointer |
| sp_out | output | 8 | Updated stack pointer, valid with sp_load |
| ram_we | output | 1 | Stack RAM write strobe |
| ram_addr | output | 8 | Stack RAM write address |
| ram_wdata | output | 8 | Stack RAM write data |

## Verification
The functions that can collide are the acceptance of a new start request and the sequence still running for the previous instruction. This is most pointed in the pc_load cycle, where the sequencer is still busy but about to return to idle. The bench holds start high across a whole call while changing the instruction inputs. It also issues jumps with start held high continuously. A cycle-by-cycle reference model decides on every edge whether a request is taken. Every output is compared against that model, so any early acceptance, or any leak of the new operands into the pushed bytes or the target, shows up as a mismatch.

// File: rtl/abs_branch_pkg.sv
package abs_branch_pkg;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_PUSH_LO = 2'd1,
      ST_PUSH_HI = 2'd2,
      ST_LOAD_PC = 2'd3
   } seq_state_e;

endpackage

// File: rtl/abs_target_calc.sv
module abs_target_calc #(
   parameter int PC_W      = 16,
   parameter int DATA_W    = 8,
   parameter int PAGE_BITS = 11
) (
   input  logic [PC_W-1:0]   pc_in,
   input  logic [DATA_W-1:0] op_byte,
   input  logic [DATA_W-1:0] addr_byte,
   output logic [PC_W-1:0]   adv_pc,
   output logic [PC_W-1:0]   target
);
   localparam int OP_BITS = PAGE_BITS - DATA_W;

   logic [PAGE_BITS-1:0] page_off;

   // step past the two-byte instruction first
   assign adv_pc = pc_in + PC_W'(2);

   generate
      if (OP_BITS > 0) begin : g_op_bits
         assign page_off = {op_byte[DATA_W-1 -: OP_BITS], addr_byte};
         if (OP_BITS < DATA_W) begin : g_op_rest
            logic unused_op_low;
            assign unused_op_low = ^op_byte[DATA_W-OP_BITS-1:0];
         end
      end else begin : g_byte_only
         logic unused_op_all;
         assign page_off      = addr_byte;
         assign unused_op_all = ^op_byte;
      end
   endgenerate

   assign target = {adv_pc[PC_W-1:PAGE_BITS], page_off};

endmodule

// File: rtl/abs_seq_fsm.sv
module abs_seq_fsm
   import abs_branch_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       is_call,
   output seq_state_e state,
   output logic       accept
);
   seq_state_e state_nx;

   assign accept = (state == ST_IDLE) && start;

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_IDLE:    if (start) state_nx = is_call ? ST_PUSH_LO : ST_LOAD_PC;
         ST_PUSH_LO: state_nx = ST_PUSH_HI;
         ST_PUSH_HI: state_nx = ST_LOAD_PC;
         ST_LOAD_PC: state_nx = ST_IDLE;
         default:    state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= state_nx;
   end

endmodule

// File: rtl/abs_stack_ctl.sv
module abs_stack_ctl
   import abs_branch_pkg::*;
#(
   parameter int PC_W   = 16,
   parameter int DATA_W = 8,
   parameter int SP_W   = 8
) (
   input  seq_state_e        state,
   input  logic              call_q,
   input  logic [SP_W-1:0]   sp_q,
   input  logic [PC_W-1:0]   ret_q,
   output logic              ram_we,
   output logic [SP_W-1:0]   ram_addr,
   output logic [DATA_W-1:0] ram_wdata,
   output logic              sp_load,
   output logic [SP_W-1:0]   sp_out
);
   localparam int NBYTES = PC_W / DATA_W;

   logic [DATA_W-1:0] ret_bytes [NBYTES];
   logic [SP_W-1:0]   slot_lo;
   logic [SP_W-1:0]   slot_hi;

   genvar gi;
   generate
      for (gi = 0; gi < NBYTES; gi++) begin : g_split
         assign ret_bytes[gi] = ret_q[gi*DATA_W +: DATA_W];
      end
   endgenerate

   // pre-increment before each byte; wraps naturally at SP_W bits
   assign slot_lo = sp_q + SP_W'(1);
   assign slot_hi = sp_q + SP_W'(2);

   always_comb begin
      ram_we    = 1'b0;
      ram_addr  = '0;
      ram_wdata = '0;
      unique case (state)
         ST_PUSH_LO: begin
            ram_we    = 1'b1;
            ram_addr  = slot_lo;
            ram_wdata = ret_bytes[0];
         end
         ST_PUSH_HI: begin
            ram_we    = 1'b1;
            ram_addr  = slot_hi;
            ram_wdata = ret_bytes[NBYTES-1];
         end
         default: ;
      endcase
   end

   assign sp_load = (state == ST_LOAD_PC) && call_q;
   assign sp_out  = sp_load ? slot_hi : '0;

endmodule

// File: rtl/abs_branch_seq.sv
module abs_branch_seq
   import abs_branch_pkg::*;
#(
   parameter int PC_W      = 16,
   parameter int DATA_W    = 8,
   parameter int SP_W      = 8,
   parameter int PAGE_BITS = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              is_call,
   input  logic [PC_W-1:0]   pc_in,
   input  logic [DATA_W-1:0] op_byte,
   input  logic [DATA_W-1:0] addr_byte,
   input  logic [SP_W-1:0]   sp_in,
   output logic              busy,
   output logic              pc_load,
   output logic [PC_W-1:0]   pc_out,
   output logic              sp_load,
   output logic [SP_W-1:0]   sp_out,
   output logic              ram_we,
   output logic [SP_W-1:0]   ram_addr,
   output logic [DATA_W-1:0] ram_wdata
);
   generate
      if (PC_W != 2 * DATA_W) begin : g_bad_pcw
         $error("abs_branch_seq: PC_W must be two data bytes");
      end
      if (PAGE_BITS < DATA_W || PAGE_BITS >= PC_W) begin : g_bad_page
         $error("abs_branch_seq: PAGE_BITS out of range");
      end
      if (PAGE_BITS - DATA_W > DATA_W) begin : g_bad_op
         $error("abs_branch_seq: opcode cannot supply the page bits");
      end
   endgenerate

   seq_state_e      state;
   logic            accept;
   logic [PC_W-1:0] adv_pc;
   logic [PC_W-1:0] target;
   logic [PC_W-1:0] ret_q;
   logic [PC_W-1:0] tgt_q;
   logic [SP_W-1:0] sp_q;
   logic            call_q;

   abs_target_calc #(
      .PC_W(PC_W), .DATA_W(DATA_W), .PAGE_BITS(PAGE_BITS)
   ) u_tgt (
      .pc_in(pc_in), .op_byte(op_byte), .addr_byte(addr_byte),
      .adv_pc(adv_pc), .target(target)
   );

   abs_seq_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .start(start), .is_call(is_call),
      .state(state), .accept(accept)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ret_q  <= '0;
         tgt_q  <= '0;
         sp_q   <= '0;
         call_q <= 1'b0;
      end else if (accept) begin
         ret_q  <= adv_pc;
         tgt_q  <= target;
         sp_q   <= sp_in;
         call_q <= is_call;
      end
   end

   abs_stack_ctl #(
      .PC_W(PC_W), .DATA_W(DATA_W), .SP_W(SP_W)
   ) u_stk (
      .state(state), .call_q(call_q), .sp_q(sp_q), .ret_q(ret_q),
      .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
      .sp_load(sp_load), .sp_out(sp_out)
   );

   assign busy    = (state != ST_IDLE);
   assign pc_load = (state == ST_LOAD_PC);
   assign pc_out  = pc_load ? tgt_q : '0;

endmodule

// File: rtl/abs_branch_seq_chk.sv
module abs_branch_seq_chk #(
   parameter int SP_W = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            start,
   input logic            busy,
   input logic            pc_load,
   input logic            sp_load,
   input logic [SP_W-1:0] sp_out,
   input logic            ram_we,
   input logic [SP_W-1:0] ram_addr
);
   // R1 / R7: a write strobe never coincides with the PC load
   a_r1_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      !(ram_we && pc_load));

   // R5: the high byte goes one slot above the low byte, next cycle
   a_r5_hi_after_lo: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_we && !$past(ram_we)) |=> (ram_we && ram_addr == $past(ram_addr) + SP_W'(1)));

   // R6: the returned stack pointer equals the last slot written
   a_r6_sp_last_slot: assert property (@(posedge clk) disable iff (!rst_n)
      sp_load |-> ($past(ram_we) && sp_out == $past(ram_addr)));

   // R7: a jump loads the PC without a preceding push
   a_r7_jump_no_push: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_load && !sp_load) |-> !$past(ram_we));

   // R8: the sequencer is idle right after the PC load
   a_r8_idle_after_load: assert property (@(posedge clk) disable iff (!rst_n)
      pc_load |=> !busy);

   // R8: busy only rises on a request
   a_r8_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));

endmodule

bind abs_branch_seq abs_branch_seq_chk #(.SP_W(SP_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
   .pc_load(pc_load), .sp_load(sp_load), .sp_out(sp_out),
   .ram_we(ram_we), .ram_addr(ram_addr)
);

// File: tb/abs_branch_seq_tb.sv
module abs_branch_seq_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        is_call = 1'b0;
   logic [15:0] pc_in = '0;
   logic [7:0]  op_byte = '0;
   logic [7:0]  addr_byte = '0;
   logic [7:0]  sp_in = '0;
   logic        busy, pc_load, sp_load, ram_we;
   logic [15:0] pc_out;
   logic [7:0]  sp_out, ram_addr, ram_wdata;

   int tests = 0;
   int fails = 0;
   bit done  = 0;

   always #4 clk = ~clk;   // 125 MHz

   abs_branch_seq dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .is_call(is_call),
      .pc_in(pc_in), .op_byte(op_byte), .addr_byte(addr_byte), .sp_in(sp_in),
      .busy(busy), .pc_load(pc_load), .pc_out(pc_out),
      .sp_load(sp_load), .sp_out(sp_out),
      .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata)
   );

   typedef struct {
      bit        busy, we, pl, sl;
      bit [7:0]  addr, data, spo;
      bit [15:0] pco;
   } exp_t;

   exp_t exp_q [$];
   exp_t cur;
   exp_t idle_rec;

   // reference model, advanced on every rising edge
   always @(posedge clk) begin
      if (!rst_n) begin
         exp_q.delete();
         cur = idle_rec;
      end else begin
         bit was_busy;
         was_busy = cur.busy;
         cur = (exp_q.size() != 0) ? exp_q.pop_front() : idle_rec;
         if (!was_busy && start) begin
            bit [15:0] adv, tgt;
            exp_t r;
            adv = pc_in + 16'd2;
            tgt = {adv[15:11], op_byte[7:5], addr_byte};
            if (is_call) begin
               r = idle_rec; r.busy = 1; r.we = 1;
               r.addr = sp_in + 8'd1; r.data = adv[7:0];
               exp_q.push_back(r);
               r = idle_rec; r.busy = 1; r.we = 1;
               r.addr = sp_in + 8'd2; r.data = adv[15:8];
               exp_q.push_back(r);
               r = idle_rec; r.busy = 1; r.pl = 1; r.pco = tgt;
               r.sl = 1; r.spo = sp_in + 8'd2;
               exp_q.push_back(r);
            end else begin
               r = idle_rec; r.busy = 1; r.pl = 1; r.pco = tgt;
               exp_q.push_back(r);
            end
            cur = exp_q.pop_front();
         end
      end
   end

   task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
      end
   endtask

   // compare on every falling edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R8", "busy",    {15'd0, busy},    {15'd0, cur.busy});
         chk("R7", "ram_we",  {15'd0, ram_we},  {15'd0, cur.we});
         chk("R7", "pc_load", {15'd0, pc_load}, {15'd0, cur.pl});
         chk("R6", "sp_load", {15'd0, sp_load}, {15'd0, cur.sl});
         if (cur.we) begin
            chk("R4", "ram_addr",  {8'd0, ram_addr},  {8'd0, cur.addr});
            chk("R5", "ram_wdata", {8'd0, ram_wdata}, {8'd0, cur.data});
         end
         if (cur.pl) chk("R2", "pc_out", pc_out, cur.pco);
         if (cur.sl) chk("R6", "sp_out", {8'd0, sp_out}, {8'd0, cur.spo});
      end
   end

   task automatic issue(bit call, logic [15:0] pc, logic [7:0] op, logic [7:0] ab, logic [7:0] sp);
      @(negedge clk);
      is_call = call; pc_in = pc; op_byte = op; addr_byte = ab; sp_in = sp;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (busy) @(negedge clk);
   endtask

   initial begin : watchdog
      int cyc;
      for (cyc = 0; cyc < 20000 && !done; cyc++) @(posedge clk);
      if (!done) begin
         done = 1;
         fails++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      idle_rec = '{default: '0};
      cur = idle_rec;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1", "busy",    {15'd0, busy},    16'd0);
      chk("R1", "pc_load", {15'd0, pc_load}, 16'd0);
      chk("R1", "sp_load", {15'd0, sp_load}, 16'd0);
      chk("R1", "ram_we",  {15'd0, ram_we},  16'd0);
      rst_n = 1'b1;
      @(negedge clk);

      issue(1, 16'h1234, 8'hB1, 8'h56, 8'h07);   // R2 R4 R5 R6 plain call
      issue(0, 16'h4A10, 8'h61, 8'hC3, 8'h20);   // R7 plain jump
      issue(1, 16'h07FE, 8'h11, 8'h00, 8'h30);   // R3 page crossing via advance
      issue(0, 16'hF7FF, 8'hE1, 8'hFF, 8'h00);   // R3 jump crossing page
      issue(1, 16'h2000, 8'hF1, 8'hAA, 8'hFE);   // R6 stack wrap FF -> 00
      issue(1, 16'hFFFF, 8'h51, 8'h9C, 8'hFF);   // R2 counter wrap, R6 slot wrap

      // R8: start held during a call with changed operands is ignored
      @(negedge clk);
      is_call = 1; pc_in = 16'h3456; op_byte = 8'h71; addr_byte = 8'h12; sp_in = 8'h40;
      start = 1'b1;
      @(negedge clk);
      is_call = 0; pc_in = 16'h9999; op_byte = 8'h01; addr_byte = 8'h55; sp_in = 8'h80;
      @(negedge clk);
      @(negedge clk);
      start = 1'b0;
      while (busy) @(negedge clk);

      // R8: jumps with start held high continuously
      @(negedge clk);
      is_call = 0; pc_in = 16'h0100; op_byte = 8'h21; addr_byte = 8'h34; start = 1'b1;
      repeat (6) @(negedge clk);
      start = 1'b0;
      repeat (3) @(negedge clk);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule